// File: doc/BRIEF.md
# PHY Vendor Status and Control Register Bank

This block holds three vendor-specific management registers of an Ethernet PHY. Its access port is a plain register interface: an address, write data, a write enable, and read data that follow the address combinationally. The first register counts receive errors. It adds one on every clock in which the receive error strobe is high while receive data-valid is also high, and it stops at its maximum instead of wrapping. The second register controls the cable test. It holds a cable pair select field and a start bit. The start bit clears itself when the test logic pulses its done input. The third register holds an LED disable bit and a three-bit LED on-time code.

Two resets are kept apart. The active-low asynchronous hardware reset loads every register with its default. The one-cycle software reset pulse leaves all register contents as they are. The current control field values are also driven onto dedicated outputs, so that the cable tester and the LED driver can use them.

Top module: `phy_mgmt_bank`

## Requirements
- R1: A read of address 21 returns the error count. The count rises by exactly one after each clock edge at which rxDataValid and rxError are both 1.
- R2: An rxError pulse while rxDataValid is 0 leaves the error count unchanged.
- R3: The error count stops at 0xFFFF and stays there while further errors arrive. It never wraps to 0.
- R4: After a hardware reset (hwRstN low), address 21 reads 0x0000, address 22 reads 0x0000 and address 24 reads 0x4000.
- R5: A software reset pulse (swRst high for one cycle) changes none of the three registers.
- R6: Address 22 keeps the written bits 9:8 (pair select) and bit 0 (test start). Bits 15:10 and 7:1 always read 0. Pair select reads back as written, including the reserved codes 10 and 11.
- R7: The test start bit clears on the clock edge at which cableTestDone is 1. If a write to address 22 happens at the same edge, the written value of bit 0 takes effect instead.
- R8: Address 24 keeps the written bit 15 (LED disable) and bits 14:12 (on-time code). All other bits read 0.
- R9: A read of any address other than 21, 22 and 24 returns 0x0000. A write to such an address, or to address 21, changes no register.
- R10: The outputs pairSel, testStart, ledOff and ledOnCode always equal the corresponding stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hwRstN | input | 1 | Asynchronous active-low hardware reset |
| swRst | input | 1 | One-cycle software reset pulse |
| regAddr | input | 5 | Register address |
| regWrData | input | 16 | Write data |
| regWrEn | input | 1 | Write enable |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| rxDataValid | input | 1 | Receive data-valid strobe |
| rxError | input | 1 | Receive error strobe |
| cableTestDone | input | 1 | Cable test finished pulse |
| pairSel | output | 2 | Selected cable pair |
| testStart | output | 1 | Cable test running |
| ledOff | output | 1 | LEDs disabled |
| ledOnCode | output | 3 | LED on-time code |

## Verification
Read data is combinational, so a wrong stored value appears on regRdData, and on the field outputs, in the first cycle after the faulty clock edge. The count has two failure modes. A miscount from a dropped or spurious increment stays visible in every later read of address 21. A wrap instead of saturation shows only after more than 65535 qualified errors, so the bench drives that many errors directly. A faulty decode, a wrong reserved-bit mask or a wrong start-bit priority shows up as a wrong read value in the cycle right after the write or the done pulse. A software reset that disturbs a register shows up as a changed value in the read immediately after the pulse.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  typedef struct packed {
    logic wrCable;
    logic wrLed;
    logic rdErr;
    logic rdCable;
    logic rdLed;
  } regStrobes_t;

  localparam int PAIR_LSB  = 8;
  localparam int PAIR_W    = 2;
  localparam int START_BIT = 0;
  localparam int LEDOFF_BIT = 15;
  localparam int LEDCODE_LSB = 12;
  localparam int LEDCODE_W = 3;
  localparam logic [LEDCODE_W-1:0] LEDCODE_RST = 3'b100;
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int ERR_ADDR  = 21,
  parameter int CBL_ADDR  = 22,
  parameter int LED_ADDR  = 24
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] ERR_A = ADDR_W'(ERR_ADDR);
  localparam logic [ADDR_W-1:0] CBL_A = ADDR_W'(CBL_ADDR);
  localparam logic [ADDR_W-1:0] LED_A = ADDR_W'(LED_ADDR);

  logic hitErr, hitCable, hitLed;

  always_comb begin
    hitErr   = (regAddr == ERR_A);
    hitCable = (regAddr == CBL_A);
    hitLed   = (regAddr == LED_A);
    strobes.rdErr   = hitErr;
    strobes.rdCable = hitCable;
    strobes.rdLed   = hitLed;
    strobes.wrCable = regWrEn && hitCable;
    strobes.wrLed   = regWrEn && hitLed;
  end
endmodule

// File: rtl/phy_mgmt_dp.sv
module phy_mgmt_dp
  import phy_mgmt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  logic              swRst,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              rxDataValid,
  input  logic              rxError,
  input  logic              cableTestDone,
  output logic [DATA_W-1:0] regRdData,
  output logic [PAIR_W-1:0] pairSel,
  output logic              testStart,
  output logic              ledOff,
  output logic [LEDCODE_W-1:0] ledOnCode
);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] errCount;
  logic              countHit;

  assign countHit = rxDataValid && rxError;

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) errCount <= '0;
    else if (countHit && errCount != CNT_MAX) errCount <= errCount + 1'b1;
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      pairSel   <= '0;
      testStart <= 1'b0;
    end else if (strobes.wrCable) begin
      pairSel   <= regWrData[PAIR_LSB +: PAIR_W];
      testStart <= regWrData[START_BIT];
    end else if (cableTestDone) begin
      testStart <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      ledOff    <= 1'b0;
      ledOnCode <= LEDCODE_RST;
    end else if (strobes.wrLed) begin
      ledOff    <= regWrData[LEDOFF_BIT];
      ledOnCode <= regWrData[LEDCODE_LSB +: LEDCODE_W];
    end
  end

  always_comb begin
    regRdData = '0;
    if (strobes.rdErr) regRdData = errCount;
    else if (strobes.rdCable) begin
      regRdData[PAIR_LSB +: PAIR_W] = pairSel;
      regRdData[START_BIT]          = testStart;
    end else if (strobes.rdLed) begin
      regRdData[LEDOFF_BIT]                 = ledOff;
      regRdData[LEDCODE_LSB +: LEDCODE_W]   = ledOnCode;
    end
  end

  // R1: one qualified error adds exactly one below the ceiling
  p_count_step_r1: assert property (@(posedge clk) disable iff (!hwRstN)
    (countHit && errCount != CNT_MAX) |=> errCount == $past(errCount) + 1'b1);

  // R2: no qualified error, no change
  p_ignore_r2: assert property (@(posedge clk) disable iff (!hwRstN)
    !countHit |=> $stable(errCount));

  // R3: the ceiling holds
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!hwRstN)
    errCount == CNT_MAX |=> errCount == CNT_MAX);

  // R5: software reset leaves the LED register alone
  p_swrst_keep_r5: assert property (@(posedge clk) disable iff (!hwRstN)
    (swRst && !strobes.wrLed) |=> ($stable(ledOff) && $stable(ledOnCode)));

  // R7: done clears start unless a write lands in the same cycle
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!hwRstN)
    (cableTestDone && !strobes.wrCable) |=> !testStart);
endmodule

// File: rtl/phy_mgmt_bank.sv
module phy_mgmt_bank
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  logic              swRst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rxDataValid,
  input  logic              rxError,
  input  logic              cableTestDone,
  output logic [1:0]        pairSel,
  output logic              testStart,
  output logic              ledOff,
  output logic [2:0]        ledOnCode
);
  regStrobes_t strobes;

  phy_mgmt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  phy_mgmt_dp #(.DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .hwRstN        (hwRstN),
    .swRst         (swRst),
    .strobes       (strobes),
    .regWrData     (regWrData),
    .rxDataValid   (rxDataValid),
    .rxError       (rxError),
    .cableTestDone (cableTestDone),
    .regRdData     (regRdData),
    .pairSel       (pairSel),
    .testStart     (testStart),
    .ledOff        (ledOff),
    .ledOnCode     (ledOnCode)
  );
endmodule

// File: tb/phy_mgmt_bank_tb.sv
module phy_mgmt_bank_tb;
  logic clk = 0;
  logic hwRstN = 0, swRst = 0, regWrEn = 0;
  logic [4:0] regAddr = 0;
  logic [15:0] regWrData = 0, regRdData;
  logic rxDataValid = 0, rxError = 0, cableTestDone = 0;
  logic [1:0] pairSel;
  logic testStart, ledOff;
  logic [2:0] ledOnCode;

  int nTests = 0, nFail = 0;
  logic [15:0] mCnt;
  logic [1:0] mPair;
  logic mStart, mLedOff;
  logic [2:0] mCode;
  bit finished = 0;

  always #5 clk = ~clk;

  phy_mgmt_bank u_dut (.*);

  function automatic logic [15:0] expRead(input logic [4:0] a);
    case (a)
      5'd21: return mCnt;
      5'd22: return {6'b0, mPair, 7'b0, mStart};
      5'd24: return {mLedOff, mCode, 12'b0};
      default: return 16'h0;
    endcase
  endfunction

  task automatic modelReset();
    mCnt = 0; mPair = 0; mStart = 0; mLedOff = 0; mCode = 3'b100;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock with the given inputs, model updated at the edge
  task automatic step(input logic [4:0] a, input logic [15:0] wd, input logic we,
                      input logic dv, input logic er, input logic dn, input logic sw);
    @(negedge clk);
    regAddr = a; regWrData = wd; regWrEn = we;
    rxDataValid = dv; rxError = er; cableTestDone = dn; swRst = sw;
    @(posedge clk);
    if (dv && er && mCnt != 16'hFFFF) mCnt = mCnt + 1;
    if (we && a == 5'd22) begin mPair = wd[9:8]; mStart = wd[0]; end
    else if (dn) mStart = 0;
    if (we && a == 5'd24) begin mLedOff = wd[15]; mCode = wd[14:12]; end
    @(negedge clk);
    regWrEn = 0; rxDataValid = 0; rxError = 0; cableTestDone = 0; swRst = 0;
  endtask

  task automatic readChk(input string req, input logic [4:0] a);
    regAddr = a;
    #1;
    check(req, regRdData, expRead(a));
  endtask

  task automatic outChk(input string req);
    check(req, {11'b0, pairSel, testStart, ledOff, ledOnCode},
          {11'b0, mPair, mStart, mLedOff, mCode});
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    modelReset();
    repeat (3) @(negedge clk);
    hwRstN = 1;
    @(negedge clk);
    readChk("R4 cnt", 21); readChk("R4 cable", 22); readChk("R4 led", 24);
    check("R4 led value", regRdData, 16'h4000);
    outChk("R10 reset");

    // R1 / R2
    step(21, 0, 0, 1, 1, 0, 0); readChk("R1 one error", 21);
    step(21, 0, 0, 0, 1, 0, 0); readChk("R2 error without valid", 21);
    step(21, 0, 0, 1, 0, 0, 0); readChk("R2 valid without error", 21);

    // R6 / R8 masks
    step(22, 16'hFFFF, 1, 0, 0, 0, 0); readChk("R6 all ones", 22);
    check("R6 value", regRdData, 16'h0301);
    step(24, 16'hFFFF, 1, 0, 0, 0, 0); readChk("R8 all ones", 24);
    check("R8 value", regRdData, 16'hF000);
    outChk("R10 after writes");

    // R7 done clears, collision keeps set
    step(0, 0, 0, 0, 0, 1, 0); readChk("R7 done clears", 22);
    check("R7 start low", {15'b0, testStart}, 16'h0);
    step(22, 16'h0201, 1, 0, 0, 1, 0); readChk("R7 write wins", 22);
    check("R7 start high", {15'b0, testStart}, 16'h1);

    // R9 unimplemented / counter write
    step(21, 16'h1234, 1, 0, 0, 0, 0); readChk("R9 counter write ignored", 21);
    step(5, 16'hFFFF, 1, 0, 0, 0, 0); readChk("R9 unmapped read", 5);
    readChk("R9 cable intact", 22); readChk("R9 led intact", 24);
    step(23, 16'hFFFF, 1, 0, 0, 0, 0); readChk("R9 addr23", 23);
    readChk("R9 led intact 2", 24);

    // R5 software reset
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    readChk("R5 cnt", 21); readChk("R5 cable", 22); readChk("R5 led", 24);
    outChk("R10 after swrst");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] a;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 4));
      a = (pick == 0) ? 5'd21 : (pick == 1) ? 5'd22 : (pick == 2) ? 5'd24 : 5'($urandom);
      step(a, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 15) == 0));
      readChk("R1 R6 R7 R8 R9 random", 5'($urandom_range(16, 31)));
      if (i % 100 == 0) begin readChk("R1 random cnt", 21); outChk("R10 random"); end
    end

    // R3 saturation
    @(negedge clk);
    regAddr = 21; rxDataValid = 1; rxError = 1;
    for (int k = 0; k < 66000; k++) begin
      @(posedge clk);
      if (mCnt != 16'hFFFF) mCnt = mCnt + 1;
    end
    @(negedge clk);
    rxDataValid = 0; rxError = 0;
    readChk("R3 saturated", 21);
    check("R3 value", regRdData, 16'hFFFF);
    step(21, 0, 0, 1, 1, 0, 0); readChk("R3 stays", 21);

    // R4 hardware reset again
    @(negedge clk); hwRstN = 0; modelReset();
    @(negedge clk); hwRstN = 1;
    readChk("R4 cnt again", 21); readChk("R4 cable again", 22); readChk("R4 led again", 24);
    outChk("R10 after reset");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule